// File: doc/BRIEF.md
# Injected Sequence Context Queue

This block stores the configuration contexts of an ADC's injected conversion group. A context is one configuration word holding a sequence length, a trigger edge select, a trigger source select and four channel numbers, one per rank. Each write of the word delivers a whole context; the fields are never updated one at a time. The block shows the active context to a downstream sequencer and gates incoming trigger events against it. The sequencer retires the active context with a one-cycle done pulse.

The block has two operating modes, chosen by a queue-disable input. With the queue disabled there is a single context: each write replaces it, and it stays active until the next write. With the queue enabled, contexts pass through a two-entry first-in first-out store. A write to a full queue is dropped and sets a sticky overflow flag, which also acts as an interrupt request. A keep-last input selects what happens when the final context is retired: either it stays active, or the queue empties and triggers are ignored until a new write arrives. Any change of the queue-disable input flushes the store and clears the active word to zero.

Top module: `inj_ctx_queue`

## Requirements
- R1: The context word is laid out as length minus one in bits [1:0], edge select in [3:2], source select in [5:4], and the channel number for rank k (k = 0..3) in bits [6+5k +: 5]. An accepted write stores all 26 bits unchanged, and `ctx_word` returns them exactly.
- R2: With the queue enabled, at most two contexts are held. They become active in the order they were written.
- R3: With the queue enabled, a write while two contexts are held and no retire happens in the same cycle is dropped. The queue contents stay unchanged and `ovf_flag` is set on the next cycle.
- R4: With the queue enabled, a write in the same cycle as a retire of the active context in a full queue is accepted, and no overflow is flagged.
- R5: `ovf_flag` stays set until a cycle with `ovf_clr` high clears it. If a new overflow occurs in the same cycle as a clear, the flag stays set.
- R6: With the queue disabled, each write replaces the single context, `ctx_valid` is 1, `seq_done` has no effect, and no overflow ever occurs.
- R7: With the queue enabled and one context held, a retire while `keep_last` is 1 leaves that context active. While `keep_last` is 0, the retire empties the queue: `ctx_valid` goes to 0 and `ctx_word` to zero.
- R8: Source select 0 means software start. `sw_start` fires a trigger only with the queue disabled. With the queue enabled it is ignored.
- R9: Source select k (1..3) watches `ext_trig[k-1]` only. Edge select 0 fires on a rising edge, 1 on a falling edge, and 2 or 3 on both. With source select 0, the edge select and all external lines have no effect. While `ctx_valid` is 0, no trigger fires.
- R10: Any change of `qdis` empties the queue and clears `ctx_word` to zero on the next cycle. A write in the cycle of the change is dropped.
- R11: `ctx_word` always shows the active (oldest) context, never the pending one.
- R12: After reset, `ctx_word` is zero, `ovf_flag` is 0 and no context is queued. The block assumes `qdis` is 1 at reset, so `ctx_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qdis | input | 1 | 1: single static context, 0: two-entry queue |
| keep_last | input | 1 | 1: last queued context stays active after retire |
| wr_en | input | 1 | Context write strobe |
| wr_data | input | 26 | Context word to write |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| seq_done | input | 1 | One-cycle pulse retiring the active context |
| sw_start | input | 1 | Software start request |
| ext_trig | input | 3 | External trigger lines |
| ctx_word | output | 26 | Active context (read-back value) |
| ctx_valid | output | 1 | A context is active |
| trig_fire | output | 1 | Accepted trigger for the sequencer |
| ovf_flag | output | 1 | Sticky overflow flag and interrupt request |

## Verification
On every cycle, the embedded assertions check the following: the queue depth bound, that the overflow flag stays set until cleared, that a flush leaves an empty store with a zero word, that static mode never overflows, that an empty or queued-software configuration never fires, and that keep-last holds the last context. Only the bench scenarios can show the rest: FIFO ordering, dropping of an overflowing write, the simultaneous retire-and-write case, and the exact edge response of each source and edge combination. For that last point, the bench sweeps every source and edge code against every external line.

// File: rtl/inj_ctx_pkg.sv
package inj_ctx_pkg;

  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;

  // Trigger-edge decision: rising, falling, or both edges of the selected line.
  function automatic logic edge_hit(input logic [1:0] sel, input logic now, input logic prev);
    logic rise, fall;
    rise = now & ~prev;
    fall = ~now & prev;
    case (sel)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      default:   edge_hit = rise | fall;
    endcase
  endfunction

endpackage

// File: rtl/ctx_fifo2.sv
module ctx_fifo2 #(
  parameter int CTX_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             static_mode,
  input  logic             keep_last,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [CTX_W-1:0] wr_data,
  input  logic             pop_req,
  output logic [CTX_W-1:0] head,
  output logic [1:0]       count,
  output logic             ovf_evt
);

  logic [CTX_W-1:0] slot1;
  logic             full, pop_ok, push_ok;

  assign full    = (count == 2'd2);
  assign pop_ok  = !static_mode && !flush && pop_req && (count != 2'd0)
                   && !((count == 2'd1) && keep_last);
  assign push_ok = wr_en && !flush && (static_mode || !full || pop_ok);
  assign ovf_evt = wr_en && !flush && !static_mode && full && !pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      slot1 <= '0;
      count <= 2'd0;
    end else if (flush) begin
      head  <= '0;
      slot1 <= '0;
      count <= 2'd0;
    end else if (static_mode) begin
      if (wr_en) head <= wr_data;
    end else begin
      case ({push_ok, pop_ok})
        2'b10: begin
          if (count == 2'd0) head <= wr_data;
          else               slot1 <= wr_data;
          count <= count + 2'd1;
        end
        2'b01: begin
          head  <= slot1;
          slot1 <= '0;
          count <= count - 2'd1;
        end
        2'b11: begin
          if (count == 2'd1) head <= wr_data;
          else begin
            head  <= slot1;
            slot1 <= wr_data;
          end
        end
        default: ;
      endcase
    end
  end

  AST_DEPTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    count != 2'd3); // R2

  AST_KEEP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!static_mode && keep_last && count == 2'd1 && pop_req && !wr_en && !flush)
      |=> (count == 2'd1 && $stable(head))); // R7

endmodule

// File: rtl/trig_gate.sv
module trig_gate
  import inj_ctx_pkg::*;
#(
  parameter int SRC_W = 2,
  localparam int N_EXT = (1 << SRC_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_trig,
  input  logic             sw_start,
  input  logic             queue_mode,
  input  logic             ctx_live,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [1:0]       edge_sel,
  output logic             fire
);

  logic [N_EXT-1:0] ext_q;
  logic             line_now, line_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= ext_trig;
  end

  always_comb begin
    line_now  = 1'b0;
    line_prev = 1'b0;
    for (int k = 0; k < N_EXT; k++) begin
      if (src_sel == SRC_W'(k + 1)) begin
        line_now  = ext_trig[k];
        line_prev = ext_q[k];
      end
    end
  end

  assign fire = ctx_live && ((src_sel == '0) ? (sw_start && !queue_mode)
                                             : edge_hit(edge_sel, line_now, line_prev));

  AST_QUEUE_NO_SWSTART: assert property (@(posedge clk) disable iff (!rst_n)
    (queue_mode && src_sel == '0) |-> !fire); // R8

endmodule

// File: rtl/inj_ctx_queue.sv
module inj_ctx_queue #(
  parameter int   RANKS    = 4,
  parameter int   CH_W     = 5,
  parameter int   SRC_W    = 2,
  parameter logic QDIS_RST = 1'b1,
  localparam int  LEN_W    = $clog2(RANKS),
  localparam int  EDGE_LSB = LEN_W,
  localparam int  SRC_LSB  = LEN_W + 2,
  localparam int  CTX_W    = LEN_W + 2 + SRC_W + RANKS * CH_W,
  localparam int  N_EXT    = (1 << SRC_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qdis,
  input  logic             keep_last,
  input  logic             wr_en,
  input  logic [CTX_W-1:0] wr_data,
  input  logic             ovf_clr,
  input  logic             seq_done,
  input  logic             sw_start,
  input  logic [N_EXT-1:0] ext_trig,
  output logic [CTX_W-1:0] ctx_word,
  output logic             ctx_valid,
  output logic             trig_fire,
  output logic             ovf_flag
);

  logic       qdis_q, flush_evt, ovf_evt;
  logic [1:0] depth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qdis_q <= QDIS_RST;
    else        qdis_q <= qdis;
  end
  assign flush_evt = qdis ^ qdis_q;

  ctx_fifo2 #(.CTX_W(CTX_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .static_mode(qdis), .keep_last(keep_last),
    .flush(flush_evt), .wr_en(wr_en), .wr_data(wr_data), .pop_req(seq_done),
    .head(ctx_word), .count(depth), .ovf_evt(ovf_evt)
  );

  assign ctx_valid = qdis || (depth != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_evt) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  trig_gate #(.SRC_W(SRC_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .sw_start(sw_start),
    .queue_mode(!qdis), .ctx_live(ctx_valid),
    .src_sel(ctx_word[SRC_LSB +: SRC_W]), .edge_sel(ctx_word[EDGE_LSB +: 2]),
    .fire(trig_fire)
  );

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (depth == 2'd0 && ctx_word == '0)); // R10

  AST_STATIC_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    qdis |-> !ovf_evt); // R6

  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_valid |-> !trig_fire); // R9

endmodule

// File: tb/tb_inj_ctx_queue.sv
`timescale 1ns/1ps
module tb_inj_ctx_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qdis = 1'b1, keep_last = 1'b0, wr_en = 1'b0, ovf_clr = 1'b0;
  logic        seq_done = 1'b0, sw_start = 1'b0;
  logic [25:0] wr_data = '0;
  logic [2:0]  ext_trig = '0;
  logic [25:0] ctx_word;
  logic        ctx_valid, trig_fire, ovf_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  inj_ctx_queue dut (
    .clk(clk), .rst_n(rst_n), .qdis(qdis), .keep_last(keep_last), .wr_en(wr_en),
    .wr_data(wr_data), .ovf_clr(ovf_clr), .seq_done(seq_done), .sw_start(sw_start),
    .ext_trig(ext_trig), .ctx_word(ctx_word), .ctx_valid(ctx_valid),
    .trig_fire(trig_fire), .ovf_flag(ovf_flag)
  );

  function automatic logic [25:0] mk(input int len, input int edg, input int src, input int base);
    logic [25:0] w;
    w = '0;
    w[1:0] = 2'(len);
    w[3:2] = 2'(edg);
    w[5:4] = 2'(src);
    for (int k = 0; k < 4; k++) w[6 + 5*k +: 5] = 5'((base + 7*k) % 32);
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wr(input logic [25:0] w); wr_en = 1'b1; wr_data = w; tick(); wr_en = 1'b0; endtask
  task automatic done(); seq_done = 1'b1; tick(); seq_done = 1'b0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [25:0] a, b, c, w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R12 reset state
    check("R12 word", ctx_word, 0);
    check("R12 ovf", ovf_flag, 0);
    check("R12 valid", ctx_valid, 1);
    check("R12 fire", trig_fire, 0);

    // R1 R6 R8 R9 sweep of every source and edge code in static mode
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        w = mk(s, e, s, 4*s + e);
        wr(w);
        check("R1 word", ctx_word, w);
        done();
        check("R6 done ignored", ctx_word, w);
        check("R6 valid", ctx_valid, 1);
        ext_trig = '0; tick();
        for (int j = 0; j < 3; j++) begin
          ext_trig[j] = 1'b1; #1;
          check("R9 rise", trig_fire, (s == j + 1) && (e != 1));
          tick();
          ext_trig[j] = 1'b0; #1;
          check("R9 fall", trig_fire, (s == j + 1) && (e != 0));
          tick();
        end
        sw_start = 1'b1; #1;
        check("R8 static swstart", trig_fire, s == 0);
        sw_start = 1'b0;
        tick();
      end
    end
    wr(mk(0, 0, 1, 3)); wr(mk(0, 0, 2, 9));
    check("R6 no ovf", ovf_flag, 0);

    // R10 switch to queue mode flushes
    qdis = 1'b0; tick();
    check("R10 flush word", ctx_word, 0);
    check("R10 flush valid", ctx_valid, 0);

    // R2 R3 R11 ordering and overflow
    a = mk(3, 0, 1, 1); b = mk(2, 1, 0, 11); c = mk(1, 2, 3, 21);
    ext_trig = 3'b001; #1;
    check("R9 empty no fire", trig_fire, 0);
    tick(); ext_trig = '0; tick();
    wr(a);
    check("R2 first", ctx_word, a);
    wr(b);
    check("R11 active only", ctx_word, a);
    wr(c);
    check("R3 ovf set", ovf_flag, 1);
    check("R3 head kept", ctx_word, a);
    tick();
    check("R5 sticky", ovf_flag, 1);
    done();
    check("R2 second", ctx_word, b);
    sw_start = 1'b1; #1;
    check("R8 queue swstart ignored", trig_fire, 0);
    sw_start = 1'b0;
    done();
    check("R7 empty valid", ctx_valid, 0);
    check("R7 empty word", ctx_word, 0);
    check("R3 dropped write absent", ctx_valid, 0);

    // R5 clear, and set wins over clear
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    check("R5 cleared", ovf_flag, 0);
    wr(a); wr(b);
    ovf_clr = 1'b1; wr(c); ovf_clr = 1'b0;
    check("R5 set wins", ovf_flag, 1);
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    check("R5 cleared again", ovf_flag, 0);

    // R4 write with retire when full
    seq_done = 1'b1; wr(c); seq_done = 1'b0;
    check("R4 no ovf", ovf_flag, 0);
    check("R4 advance", ctx_word, b);
    done();
    check("R4 accepted", ctx_word, c);

    // R7 keep last
    keep_last = 1'b1;
    done(); done();
    check("R7 kept word", ctx_word, c);
    check("R7 kept valid", ctx_valid, 1);
    ext_trig = 3'b100; #1;
    check("R9 queue ext fire", trig_fire, 1);
    tick(); ext_trig = '0; tick();
    wr(a);
    check("R11 pending hidden", ctx_word, c);
    done();
    check("R2 kept then next", ctx_word, a);

    // R10 change back with concurrent write dropped
    qdis = 1'b1; wr(b);
    check("R10 write dropped", ctx_word, 0);
    check("R10 static valid", ctx_valid, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule